// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block holds a small table of outbound translation windows that maps request addresses from an on-chip bus into the address space of a PCIe link. Software programs each window through a word-wide register port. Each window has a source base, a translated base, a power-of-two size code, an enable bit and a 32-bit translation parameter word. The parameter word tells the downstream request builder what kind of transaction to issue. Type ID 0 means a memory access, type ID 1 means a configuration access, and bit 22 is a direction flag.

The lookup path is combinational from the stored registers. On every cycle the block compares the presented request address with all enabled windows. On a hit it returns the translated address, the parameter word of the winning window, its index and a hit flag. On a miss it raises a miss flag and passes the address through unchanged. A typical setup uses two kinds of window. One is a 256 MiB configuration window mapped to translated base 0. The others are identity-mapped memory windows.

Top module: `atr_window_table`

## Requirements
- R1: After reset, every register reads as zero and every lookup misses.
- R2: Window i occupies register byte offsets i*0x20 to i*0x20+0x1F. Register address bits 1:0 are ignored. Word 0x0 is source-low, 0x4 is source-high, 0x8 is translated-low, 0xC is translated-high and 0x10 is the parameter word. Offsets 0x14, 0x18 and 0x1C read as zero, and writes to them change nothing. Source-high, translated-high and the parameter word read back exactly as written.
- R3: Bits 11:7 of source-low and bits 11:0 of translated-low always read as zero, whatever was written to them.
- R4: Source-low bit 0 enables the window. Bits 6:1 hold a size code N, and the window covers 2^(N+1) bytes. The source base is {source-high, source-low[31:12], 12'h000}. An enabled window hits address A when A and the source base agree on every bit at or above position N+1. N = 63 matches every address.
- R5: On a hit, the translated address takes bits N+1 and up from {translated-high, translated-low[31:12], 12'h000}. It takes bits N down to 0 from A.
- R6: On a hit, the parameter output equals the winning window's parameter word, including type ID and bit 22.
- R7: When several windows hit, the lowest-numbered one wins and its index is output.
- R8: On a miss, the block drives miss=1, hit=0, translated address = A, parameter = 0 and index = 0.
- R9: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R10: A register write made at a clock edge is used by lookups from that edge onward, so it is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+5 (8) | Register byte address, shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_addr | input | 64 | Request address to translate |
| lk_trsl_addr | output | 64 | Translated address, or lk_addr on a miss |
| lk_param | output | 32 | Parameter word of the winning window, or 0 on a miss |
| lk_hit | output | 1 | A window matched |
| lk_miss | output | 1 | No window matched |
| lk_idx | output | IDX_W (3) | Index of the winning window |

## Verification
The bench probes every window at five addresses: one below its base, its base, its midpoint, its last byte and one past its end. These probes separate an off-by-one in the size decoding from a wrong comparison side. Deliberately overlapping windows are enabled and disabled in turn, so the priority order and the enable gating show in which index wins. A catch-all window with size code 63 checks the full-width mask. Hundreds of scrambled addresses, drawn near and far from the bases, compare hit, index, translated address and parameter against an arithmetic model. Register patterns with the reserved and ignored bits set, and writes to the unused offsets, show that those bits stay zero and that lookups are unaffected.

// File: rtl/atr_window_table.sv
module atr_window_table #(
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [IDX_W+4:0]     reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [63:0]          lk_addr,
  output logic [63:0]          lk_trsl_addr,
  output logic [31:0]          lk_param,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic [IDX_W-1:0]     lk_idx
);
  localparam int NUM_WIN = 1 << IDX_W;
  localparam int RA_W = IDX_W + 5;
  localparam logic [31:0] SRC_LO_KEEP = 32'hFFFF_F07F;
  localparam logic [31:0] TR_LO_KEEP  = 32'hFFFF_F000;

  logic [31:0] src_lo_q [NUM_WIN];
  logic [31:0] src_hi_q [NUM_WIN];
  logic [31:0] tr_lo_q  [NUM_WIN];
  logic [31:0] tr_hi_q  [NUM_WIN];
  logic [31:0] prm_q    [NUM_WIN];

  logic [IDX_W-1:0] acc_idx;
  logic [2:0]       acc_word;
  assign acc_idx  = reg_addr[RA_W-1:5];
  assign acc_word = reg_addr[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        src_lo_q[i] <= '0;
        src_hi_q[i] <= '0;
        tr_lo_q[i]  <= '0;
        tr_hi_q[i]  <= '0;
        prm_q[i]    <= '0;
      end
    end else if (reg_wr_en) begin
      case (acc_word)
        3'd0: src_lo_q[acc_idx] <= reg_wdata & SRC_LO_KEEP;
        3'd1: src_hi_q[acc_idx] <= reg_wdata;
        3'd2: tr_lo_q[acc_idx]  <= reg_wdata & TR_LO_KEEP;
        3'd3: tr_hi_q[acc_idx]  <= reg_wdata;
        3'd4: prm_q[acc_idx]    <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (acc_word)
      3'd0:    reg_rdata = src_lo_q[acc_idx];
      3'd1:    reg_rdata = src_hi_q[acc_idx];
      3'd2:    reg_rdata = tr_lo_q[acc_idx];
      3'd3:    reg_rdata = tr_hi_q[acc_idx];
      3'd4:    reg_rdata = prm_q[acc_idx];
      default: reg_rdata = '0;
    endcase
  end

  logic [63:0]        win_mask [NUM_WIN];
  logic [63:0]        src_base [NUM_WIN];
  logic [63:0]        tr_base  [NUM_WIN];
  logic [63:0]        trsl_vec [NUM_WIN];
  logic [NUM_WIN-1:0] match_vec;

  always_comb begin
    for (int i = 0; i < NUM_WIN; i++) begin
      win_mask[i]  = ~(64'hFFFF_FFFF_FFFF_FFFE << src_lo_q[i][6:1]);
      src_base[i]  = {src_hi_q[i], src_lo_q[i][31:12], 12'h000};
      tr_base[i]   = {tr_hi_q[i], tr_lo_q[i][31:12], 12'h000};
      match_vec[i] = src_lo_q[i][0] && (((lk_addr ^ src_base[i]) & ~win_mask[i]) == 64'd0);
      trsl_vec[i]  = (tr_base[i] & ~win_mask[i]) | (lk_addr & win_mask[i]);
    end
  end

  logic [IDX_W-1:0] sel;
  logic             any_hit;

  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel     = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign lk_hit       = any_hit;
  assign lk_miss      = !any_hit;
  assign lk_idx       = sel;
  assign lk_trsl_addr = any_hit ? trsl_vec[sel] : lk_addr;
  assign lk_param     = any_hit ? prm_q[sel] : 32'd0;

  logic [NUM_WIN-1:0] below_sel;
  assign below_sel = (NUM_WIN'(1) << lk_idx) - NUM_WIN'(1);

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_trsl_addr == lk_addr && lk_param == 32'd0)); // R8
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> src_lo_q[lk_idx][0]); // R9
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((match_vec & below_sel) == '0)); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (((lk_trsl_addr ^ lk_addr) & win_mask[lk_idx]) == 64'd0)); // R5
  AST_BASE_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (((lk_trsl_addr ^ {tr_hi_q[lk_idx], tr_lo_q[lk_idx][31:12], 12'h000}) & ~win_mask[lk_idx]) == 64'd0)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word == 3'd0) |-> (reg_rdata[11:7] == 5'd0)); // R3
  AST_PARAM_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && acc_word == 3'd4) |=> (prm_q[$past(acc_idx)] == $past(reg_wdata))); // R10
endmodule

// File: tb/tb_atr_window_table.sv
`timescale 1ns/1ps
module tb_atr_window_table;
  localparam int IDX_W = 3;
  localparam int NW = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [IDX_W+4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr = '0;
  logic [63:0] lk_trsl_addr;
  logic [31:0] lk_param;
  logic lk_hit, lk_miss;
  logic [IDX_W-1:0] lk_idx;

  always #5 clk = ~clk;

  atr_window_table #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_trsl_addr(lk_trsl_addr), .lk_param(lk_param), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_idx(lk_idx)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] m_sl [NW];
  logic [31:0] m_sh [NW];
  logic [31:0] m_tl [NW];
  logic [31:0] m_th [NW];
  logic [31:0] m_pm [NW];
  logic [63:0] rng = 64'h1234_5678_9ABC_DEF1;

  function automatic logic [63:0] m_mask(input int k);
    int n = int'(m_sl[k][6:1]);
    if (n >= 63) return '1;
    return (64'd1 << (n + 1)) - 64'd1;
  endfunction

  function automatic logic [63:0] m_base(input int k);
    return {m_sh[k], m_sl[k][31:12], 12'h000};
  endfunction

  task automatic wr(input int k, input int word, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr = (IDX_W+5)'(k * 32 + word * 4);
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (word)
      0: m_sl[k] = d & 32'hFFFF_F07F;
      1: m_sh[k] = d;
      2: m_tl[k] = d & 32'hFFFF_F000;
      3: m_th[k] = d;
      4: m_pm[k] = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input int k, input int word, input string rq);
    logic [31:0] exp;
    case (word)
      0: exp = m_sl[k];
      1: exp = m_sh[k];
      2: exp = m_tl[k];
      3: exp = m_th[k];
      4: exp = m_pm[k];
      default: exp = 32'd0;
    endcase
    reg_addr = (IDX_W+5)'(k * 32 + word * 4);
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read win %0d word %0d got %h exp %h", rq, k, word, reg_rdata, exp);
    end
  endtask

  task automatic lk_chk(input logic [63:0] a, input string rq);
    logic e_hit = 1'b0;
    int e_idx = 0;
    logic [63:0] e_tr = a;
    logic [31:0] e_pm = 32'd0;
    for (int k = 0; k < NW; k++) begin
      if (!e_hit && m_sl[k][0] && (((a ^ m_base(k)) & ~m_mask(k)) == 64'd0)) begin
        e_hit = 1'b1;
        e_idx = k;
        e_tr = ({m_th[k], m_tl[k][31:12], 12'h000} & ~m_mask(k)) | (a & m_mask(k));
        e_pm = m_pm[k];
      end
    end
    lk_addr = a;
    #1;
    checks++;
    if (lk_hit !== e_hit || lk_miss !== !e_hit || lk_idx !== IDX_W'(e_idx) ||
        lk_trsl_addr !== e_tr || lk_param !== e_pm) begin
      errors++;
      $display("FAIL %s: addr %h got hit=%b miss=%b idx=%0d tr=%h pm=%h exp hit=%b idx=%0d tr=%h pm=%h",
               rq, a, lk_hit, lk_miss, lk_idx, lk_trsl_addr, lk_param, e_hit, e_idx, e_tr, e_pm);
    end
  endtask

  task automatic probe_edges(input string rq);
    for (int k = 0; k < NW; k++) begin
      logic [63:0] b = m_base(k) & ~m_mask(k);
      logic [63:0] m = m_mask(k);
      lk_chk(b - 64'd1, rq);
      lk_chk(b, rq);
      lk_chk(b + (m >> 1), rq);
      lk_chk(b + m, rq);
      lk_chk(b + m + 64'd1, rq);
    end
  endtask

  task automatic scramble(input int count, input string rq);
    for (int j = 0; j < count; j++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      if (rng[0]) lk_chk(m_base(int'(rng[3:1])) ^ (rng >> rng[9:4]), rq);
      else lk_chk(rng, rq);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NW; k++) begin
      m_sl[k] = 0; m_sh[k] = 0; m_tl[k] = 0; m_th[k] = 0; m_pm[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 0; k < NW; k++)
      for (int w = 0; w < 8; w++) rd_chk(k, w, "R1");
    lk_chk(64'h0, "R1");
    lk_chk(64'h9000_0000, "R1");

    // R2 R3: program windows, with reserved and ignored bits set
    wr(0, 0, 32'h9000_0000 | 32'hF80 | (27 << 1) | 1); wr(0, 4, 32'h1);
    wr(1, 0, (29 << 1) | 1); wr(1, 1, 32'h4); wr(1, 2, 32'hFFF); wr(1, 3, 32'h4);
    wr(2, 0, 32'h9000_1000 | (11 << 1) | 1); wr(2, 3, 32'hABC); wr(2, 4, 32'h0040_0000);
    wr(3, 0, 32'hA000_0000 | (27 << 1)); wr(3, 2, 32'h5000_0ABC); wr(3, 4, 32'h1);
    wr(5, 0, 32'h1234_5000 | 1); wr(5, 2, 32'h7777_7FFF); wr(5, 3, 32'h1);
    wr(6, 0, 32'hFFFF_0000 | (15 << 1) | 1); wr(6, 1, 32'hFFFF_FFFF);
    wr(6, 2, 32'h0001_0000); wr(6, 4, 32'h0040_0001);
    for (int k = 0; k < NW; k++)
      for (int w = 0; w < 8; w++) rd_chk(k, w, "R2_R3");
    reg_addr = 8'h03; #1; checks++;
    if (reg_rdata !== m_sl[0]) begin
      errors++;
      $display("FAIL R2: byte-offset read got %h exp %h", reg_rdata, m_sl[0]);
    end

    // R2: unused offsets ignore writes
    wr(0, 5, 32'hFFFF_FFFF); wr(0, 6, 32'hFFFF_FFFF); wr(2, 7, 32'hFFFF_FFFF);
    rd_chk(0, 5, "R2"); rd_chk(0, 6, "R2"); rd_chk(2, 7, "R2");
    for (int k = 0; k < NW; k++) for (int w = 0; w < 5; w++) rd_chk(k, w, "R2");
    lk_chk(64'h9000_0010, "R2");

    // R4 R5 R6 R8 R9: boundaries and scrambled addresses
    probe_edges("R4_R5_R6_R8_R9");
    scramble(400, "R4_R5_R6_R8");
    lk_chk(64'h1234_5000, "R4");
    lk_chk(64'h1234_5001, "R4");
    lk_chk(64'h1234_5002, "R8");
    lk_chk(64'h0000_0004_1234_5678, "R5");
    lk_chk(64'hFFFF_FFFF_FFFF_ABCD, "R6");
    lk_chk(64'hA000_0010, "R9");

    // R7: overlap priority, then lower window disabled
    lk_chk(64'h9000_1234, "R7");
    wr(0, 0, 32'h9000_0000 | (27 << 1));
    lk_chk(64'h9000_1234, "R7");
    lk_chk(64'h9000_2234, "R7");
    wr(0, 0, 32'h9000_0000 | (27 << 1) | 1);
    lk_chk(64'h9000_1234, "R7");

    // R10: enable takes effect in the next cycle
    wr(3, 0, 32'hA000_0000 | (27 << 1) | 1);
    lk_chk(64'hA000_0010, "R10");
    wr(3, 4, 32'h0040_0000);
    lk_chk(64'hA123_4567, "R10");

    // R4: catch-all window with size code 63
    wr(7, 0, (63 << 1) | 1); wr(7, 3, 32'h8000_0000); wr(7, 4, 32'h2);
    probe_edges("R4_R7");
    scramble(300, "R4_R7");
    wr(7, 0, 32'h0);
    lk_chk(64'h5555_0000_0000_0000, "R9");
    scramble(200, "R8_R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule